// File: doc/BRIEF.md
# Branch-Capped Micro-op Allocation Stage

This stage sits between a decoded micro-op queue and a reservation station. In every cycle it looks at a window of the oldest queue slots. Starting from the oldest, it grants as many micro-ops as the current limits allow, and each granted micro-op takes one free station entry. Each entry holds one unfused micro-op.

Three separate limits apply, and the first one reached ends the cycle's allocation:

- **Lane limit.** No more than `LANES` micro-ops (default four) are allocated in one cycle.
- **Branch limit.** No more than `BR_CAP` branch micro-ops (default two) are allocated in one cycle. This limit can leave lanes empty while the queue still has work waiting. A stream made only of branches therefore moves through at two per cycle.
- **Free-entry limit.** The count of free station entries reported by the station bounds the grants. With the default size of 60, that count ranges from 0 to 60.

Allocation is strictly in program order. A slot that cannot be granted blocks every younger slot in the same cycle.

The queue reads the grant count in the same cycle and pops that many entries. A registered copy of the count is presented one cycle later for the station's write-pointer logic.

Top module: `uop_alloc_stage`

## Requirements
- R1: No more than `LANES` (default 4) grant strobes are asserted in any cycle. A full window of non-branch micro-ops with ample free entries gets all four granted.
- R2: No more than `BR_CAP` (default 2) of the granted slots in one cycle have their branch flag set.
- R3: When the next slot in order is a branch and the branch limit is already used up, it and every younger slot stay ungranted. A full window of branches is granted exactly two.
- R4: Grants form a contiguous run starting at slot 0, the oldest slot, which is bit 0 of each slot vector. A slot whose valid bit is low ends the run, even if younger slots are valid.
- R5: The number of grants never exceeds `rs_free`. When `rs_free` is 0, nothing is granted.
- R6: The grant count is the smallest of these four values:
  - the length of the leading run of valid slots;
  - `rs_free`;
  - `LANES`;
  - the zero-based index of the slot holding the third branch, when such a slot exists.
- R7: `consume_cnt` equals the number of grant strobes asserted in the same cycle.
- R8: `alloc_cnt` shows the previous cycle's `consume_cnt`. It is 0 in the cycle after a reset edge.
- R9: While `rst` is high, no grant strobe is asserted and `consume_cnt` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | LANES | Per-slot valid bit of the queue head window; bit 0 is the oldest slot |
| q_is_br | input | LANES | Per-slot flag that marks a branch micro-op |
| rs_free | input | $clog2(RS_ENTRIES+1) | Free reservation-station entries this cycle |
| alloc_en | output | LANES | Per-slot grant strobes (combinational) |
| consume_cnt | output | $clog2(LANES+1) | Number of slots the queue must pop this cycle |
| alloc_cnt | output | $clog2(LANES+1) | Registered grant count of the previous cycle |

## Verification
Some properties are checked by the assertions on every cycle:
- the lane limit, the branch limit and the free-entry limit;
- the contiguous, in-order shape of the grant vector;
- reset suppression;
- a stop-reason rule: whenever the grant run ends early at a slot that is valid and has room, that slot must be a branch and the branch limit must already be spent.

The bench scenarios cover what the properties leave open:
- the exact grant count for specific mixes, such as a third branch at each lane position;
- the one-cycle lag of the registered count;
- the agreement between the pop count and the strobes over a long pseudo-random stream.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    // Default geometry of the allocation stage.
    localparam int DEF_LANES      = 4;
    localparam int DEF_BR_CAP     = 2;
    localparam int DEF_RS_ENTRIES = 60;

    // Per-lane gating terms gathered before the in-order chain.
    typedef struct packed {
        logic valid;     // queue slot holds a micro-op
        logic under_cap; // branch budget not exceeded up to and including this lane
        logic has_room;  // a free station entry exists for this lane
    } lane_gate_t;

    // Ones count of a vector of up to 32 bits.
    function automatic int ones32(input logic [31:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/alloc_branch_budget.sv
module alloc_branch_budget #(
    parameter int LANES  = alloc_pkg::DEF_LANES,
    parameter int BR_CAP = alloc_pkg::DEF_BR_CAP
) (
    input  logic [LANES-1:0] is_br,
    output logic [LANES-1:0] within_cap
);
    localparam int SUM_W = $clog2(LANES + 1);

    // Running branch count, inclusive of each lane.
    logic [SUM_W-1:0] br_upto [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_first
                assign br_upto[g] = SUM_W'(is_br[g]);
            end else begin : g_rest
                assign br_upto[g] = br_upto[g-1] + SUM_W'(is_br[g]);
            end
            assign within_cap[g] = (int'(br_upto[g]) <= BR_CAP);
        end
    endgenerate

endmodule

// File: rtl/alloc_space_check.sv
module alloc_space_check #(
    parameter int LANES  = alloc_pkg::DEF_LANES,
    parameter int FREE_W = 6
) (
    input  logic [FREE_W-1:0] rs_free,
    output logic [LANES-1:0]  room_ok
);
    // Lane k needs k+1 free entries, since all older lanes are granted first.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign room_ok[g] = (g < int'(rs_free));
        end
    endgenerate

endmodule

// File: rtl/alloc_order_chain.sv
module alloc_order_chain #(
    parameter int LANES = alloc_pkg::DEF_LANES
) (
    input  logic                    enable,
    input  alloc_pkg::lane_gate_t   gate [LANES],
    output logic [LANES-1:0]        grant
);
    import alloc_pkg::*;

    // A lane is granted only if every older lane was granted.
    logic [LANES:0] open;

    assign open[0] = enable;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic lane_pass;
            assign lane_pass   = gate[g].valid & gate[g].under_cap & gate[g].has_room;
            assign grant[g]    = open[g] & lane_pass;
            assign open[g+1]   = grant[g];
        end
    endgenerate

endmodule

// File: rtl/alloc_count_reg.sv
module alloc_count_reg #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_in;
        end
    end

endmodule

// File: rtl/uop_alloc_stage.sv
module uop_alloc_stage #(
    parameter int LANES      = alloc_pkg::DEF_LANES,
    parameter int BR_CAP     = alloc_pkg::DEF_BR_CAP,
    parameter int RS_ENTRIES = alloc_pkg::DEF_RS_ENTRIES,
    parameter int FREE_W     = $clog2(RS_ENTRIES + 1),
    parameter int CNT_W      = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  q_valid,
    input  logic [LANES-1:0]  q_is_br,
    input  logic [FREE_W-1:0] rs_free,
    output logic [LANES-1:0]  alloc_en,
    output logic [CNT_W-1:0]  consume_cnt,
    output logic [CNT_W-1:0]  alloc_cnt
);
    import alloc_pkg::*;

    logic [LANES-1:0] br_ok;
    logic [LANES-1:0] room_ok;
    lane_gate_t       gate [LANES];

    alloc_branch_budget #(
        .LANES  (LANES),
        .BR_CAP (BR_CAP)
    ) u_budget (
        .is_br      (q_is_br),
        .within_cap (br_ok)
    );

    alloc_space_check #(
        .LANES  (LANES),
        .FREE_W (FREE_W)
    ) u_space (
        .rs_free (rs_free),
        .room_ok (room_ok)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_gate
            assign gate[g] = '{valid:     q_valid[g],
                               under_cap: br_ok[g],
                               has_room:  room_ok[g]};
        end
    endgenerate

    alloc_order_chain #(
        .LANES (LANES)
    ) u_chain (
        .enable (~rst),
        .gate   (gate),
        .grant  (alloc_en)
    );

    always_comb begin
        consume_cnt = CNT_W'(ones32(32'(alloc_en)));
    end

    alloc_count_reg #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_in (consume_cnt),
        .cnt_q  (alloc_cnt)
    );

endmodule

// File: rtl/alloc_stage_checker.sv
module alloc_stage_checker #(
    parameter int LANES  = 4,
    parameter int BR_CAP = 2,
    parameter int FREE_W = 6,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [LANES-1:0]  q_valid,
    input logic [LANES-1:0]  q_is_br,
    input logic [FREE_W-1:0] rs_free,
    input logic [LANES-1:0]  alloc_en,
    input logic [CNT_W-1:0]  consume_cnt,
    input logic [CNT_W-1:0]  alloc_cnt
);
    int   n_grant;
    int   n_br_grant;
    logic unexplained_stop;
    logic not_prefix;

    always_comb begin
        n_grant    = $countones(alloc_en);
        n_br_grant = $countones(alloc_en & q_is_br);
        unexplained_stop = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (i == n_grant && q_valid[i] && i < int'(rs_free) &&
                !(q_is_br[i] && n_br_grant == BR_CAP)) begin
                unexplained_stop = 1'b1;
            end
        end
        not_prefix = 1'b0;
        for (int i = 1; i < LANES; i++) begin
            if (alloc_en[i] && !alloc_en[i-1]) begin
                not_prefix = 1'b1;
            end
        end
    end

    AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(consume_cnt) <= LANES && n_grant <= LANES); // R1

    AST_BRANCH_CAP: assert property (@(posedge clk) disable iff (rst)
        n_br_grant <= BR_CAP); // R2

    AST_STOP_REASON: assert property (@(posedge clk) disable iff (rst)
        !unexplained_stop); // R3

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        !not_prefix && ((alloc_en & ~q_valid) == '0)); // R4

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(consume_cnt) <= int'(rs_free)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (alloc_en == '0 && consume_cnt == '0)); // R9

    AST_CNT_CLEARED: assert property (@(posedge clk)
        $past(rst) |-> (alloc_cnt == '0)); // R8

endmodule

bind uop_alloc_stage alloc_stage_checker #(
    .LANES  (LANES),
    .BR_CAP (BR_CAP),
    .FREE_W (FREE_W),
    .CNT_W  (CNT_W)
) u_alloc_chk (
    .clk         (clk),
    .rst         (rst),
    .q_valid     (q_valid),
    .q_is_br     (q_is_br),
    .rs_free     (rs_free),
    .alloc_en    (alloc_en),
    .consume_cnt (consume_cnt),
    .alloc_cnt   (alloc_cnt)
);

// File: tb/test_uop_alloc_stage.sv
module test_uop_alloc_stage;
    localparam int CLK_P  = 10;
    localparam int LANES  = 4;
    localparam int BR_CAP = 2;
    localparam int FREE_W = 6;
    localparam int CNT_W  = 3;

    typedef struct {
        logic [LANES-1:0] en;
        int               cnt;
        int               lag;
        string            req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LANES-1:0]  q_valid = '0;
    logic [LANES-1:0]  q_is_br = '0;
    logic [FREE_W-1:0] rs_free = '0;
    logic [LANES-1:0]  alloc_en;
    logic [CNT_W-1:0]  consume_cnt;
    logic [CNT_W-1:0]  alloc_cnt;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   last_cnt = 0;
    bit   driver_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uop_alloc_stage i_uop_alloc_stage (
        .clk         (clk),
        .rst         (rst),
        .q_valid     (q_valid),
        .q_is_br     (q_is_br),
        .rs_free     (rs_free),
        .alloc_en    (alloc_en),
        .consume_cnt (consume_cnt),
        .alloc_cnt   (alloc_cnt)
    );

    // Reference grant vector built from R1..R6 and R9.
    function automatic logic [LANES-1:0] ref_grant(input logic r, input logic [LANES-1:0] v,
                                                   input logic [LANES-1:0] b, input int free);
        logic [LANES-1:0] g;
        int brs;
        g = '0;
        brs = 0;
        if (!r) begin
            for (int i = 0; i < LANES; i++) begin
                if (!v[i] || i >= free || (b[i] && brs == BR_CAP)) break;
                brs += int'(b[i]);
                g[i] = 1'b1;
            end
        end
        return g;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expectation.
    task automatic drive(input logic r, input logic [LANES-1:0] v, input logic [LANES-1:0] b,
                         input int free, input string req);
        exp_t e;
        @(negedge clk);
        rst     = r;
        q_valid = v;
        q_is_br = b;
        rs_free = FREE_W'(free);
        e.en  = ref_grant(r, v, b, free);
        e.cnt = $countones(e.en);
        e.lag = last_cnt;
        e.req = req;
        last_cnt = e.cnt;
        sb.push_back(e);
    endtask

    // Monitor: compares a quarter period after the inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (alloc_en !== e.en) begin
                    n_fail++;
                    $display("FAIL %s alloc_en actual=%b expected=%b", e.req, alloc_en, e.en);
                end
                n_checks++;
                if (int'(consume_cnt) != e.cnt) begin
                    n_fail++;
                    $display("FAIL %s/R7 consume_cnt actual=%0d expected=%0d", e.req, consume_cnt, e.cnt);
                end
                n_checks++;
                if (int'(alloc_cnt) != e.lag) begin
                    n_fail++;
                    $display("FAIL R8 alloc_cnt actual=%0d expected=%0d", alloc_cnt, e.lag);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        // R9: reset holds grants off even with a full, eligible window.
        drive(1'b1, 4'b1111, 4'b0000, 60, "R9");
        drive(1'b1, 4'b1111, 4'b0101, 60, "R9");
        drive(1'b0, 4'b1111, 4'b0000, 60, "R1");   // four plain uops
        drive(1'b0, 4'b1111, 4'b1111, 60, "R3");   // all branches -> 2
        drive(1'b0, 4'b1111, 4'b1111, 60, "R3");
        drive(1'b0, 4'b1111, 4'b0011, 60, "R2");   // two branches first, then plain
        drive(1'b0, 4'b1111, 4'b1101, 60, "R6");   // third branch at lane 3 -> 3
        drive(1'b0, 4'b1111, 4'b1110, 60, "R6");   // branches at 1,2,3 -> 3
        drive(1'b0, 4'b1111, 4'b0111, 60, "R6");   // third branch at lane 2 -> 2
        drive(1'b0, 4'b1111, 4'b0000, 0,  "R5");   // station full
        drive(1'b0, 4'b1111, 4'b0000, 2,  "R5");
        drive(1'b0, 4'b1111, 4'b0000, 3,  "R5");
        drive(1'b0, 4'b1101, 4'b0000, 60, "R4");   // hole at lane 1 -> 1
        drive(1'b0, 4'b1110, 4'b0000, 60, "R4");   // oldest empty -> 0
        drive(1'b0, 4'b0011, 4'b0001, 1,  "R6");
        drive(1'b1, 4'b1111, 4'b0000, 60, "R9");   // reset mid-stream
        drive(1'b0, 4'b1111, 4'b1000, 60, "R8");
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(1'b0, lfsr[3:0] | {3'b000, lfsr[20]}, lfsr[7:4], int'(lfsr[13:8]) % 61, "R6");
        end
        @(negedge clk);
        @(negedge clk);
        driver_done = 1'b1;
    end

    initial begin
        wait (driver_done);
        wait (sb.size() == 0);
        #(CLK_P);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule